// File: doc/BRIEF.md
# Vertical-First Element Step Sequencer

This block keeps the two element position counters (source and destination) used while a vector unit runs in vertical-first order. In that order the program counter moves through a series of instructions at a fixed element position. An explicit step operation then moves both positions forward together. The block also stores the batch size that each step moves the counters by. Software asks for a batch size, and the block grants a value no larger than the request, the hardware limit or the maximum vector length.

A step moves both counters forward by the granted batch size. If either new position is at or past the vector length, both counters return to 0, vertical-first mode ends and a one-cycle rollover pulse is raised. When the record bit is set, the step also produces a 4-bit condition value. That value holds the rollover flag and, if the immediate asks for it, the inner, middle and outer loop-end flags from one of four external loop-state sources.

Top module: `vf_step_seq`

## Requirements
- R1: A step is decoded only when `op_valid`=1, `op_vf`=1, `op_vs`=0 and `op_ms`=0. Any other combination leaves `srcstep`, `dststep`, `vf_mode`, `cr0` and `cr0_valid` unchanged and raises no `rollover`.
- R2: A step that does not roll over adds the granted hint (the value held before that cycle) to both `srcstep` and `dststep`, with the result visible one clock later. The two counters are always equal.
- R3: If either incremented counter is greater than or equal to `vl`, both counters become 0, `vf_mode` clears and `rollover` is 1 for exactly one cycle, all on the clock after the step.
- R4: When `hint_valid` is 1, the granted hint becomes the minimum of `hint_req`, the parameter HW_LIMIT and `mvl`, raised to 1 if that minimum is 0. It is visible on `hint` one clock later.
- R5: A step with `op_rc`=1 and `op_imm`=1 sets `cr0_valid` for one cycle and loads `cr0` = {3'b000, rolled}. The bit layout is [3]=LT, [2]=GT, [1]=EQ, [0]=SO.
- R6: A step with `op_rc`=1 and `op_imm`=k+2 (k=0..3) loads `cr0` from loop state k, where state k occupies `loop_end[3k+2:3k]` = {outer, middle, inner}. The mapping is EQ=inner, LT=middle, GT=outer and SO=rolled.
- R7: A step with `op_rc`=1 and any other immediate loads `cr0`=0 with `cr0_valid`=1. A step with `op_rc`=0 leaves `cr0` holding its value and keeps `cr0_valid` low.
- R8: A step with `vl`=0 always rolls over and leaves both counters at 0.
- R9: After reset, `srcstep`=`dststep`=0, `hint`=1, `vf_mode`=0, `cr0`=0, `cr0_valid`=0 and `rollover`=0.
- R10: `vf_enter` sets `vf_mode` on the next clock. If a rolling step occurs in the same cycle, the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_vf | input | 1 | Vertical-first flag of the operation |
| op_vs | input | 1 | Vector-length-set flag of the operation |
| op_ms | input | 1 | Maximum-length-set flag of the operation |
| op_rc | input | 1 | Record flag: write the condition value |
| op_imm | input | 7 | Immediate; selects the condition source |
| vl | input | 7 | Current vector length |
| mvl | input | 7 | Current maximum vector length |
| hint_valid | input | 1 | Hint request present |
| hint_req | input | 7 | Requested batch size |
| vf_enter | input | 1 | Enter vertical-first mode |
| loop_end | input | 12 | Four loop states × {outer, middle, inner} end flags |
| srcstep | output | 7 | Source element position |
| dststep | output | 7 | Destination element position |
| hint | output | 7 | Granted batch size |
| vf_mode | output | 1 | Vertical-first mode active |
| rollover | output | 1 | One-cycle pulse after a rolling step |
| cr0 | output | 4 | Condition value {LT, GT, EQ, SO} |
| cr0_valid | output | 1 | Condition value written this cycle |

## Verification
All block state is visible on the outputs, so a wrong counter, hint or mode bit shows up at the ports one clock after the operation that corrupted it. A stale hint shows up at the next step as a wrong counter increment. A wrong comparison against the vector length shows up as a missing or extra rollover pulse together with counters that fail to return to zero. A behavioural reference model runs alongside the design and compares every output on every clock, so the first diverging cycle is reported directly.

// File: rtl/vf_step_pkg.sv
package vf_step_pkg;
  localparam int STEP_W = 7;
  localparam int LOOP_FLAGS = 3;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [STEP_W:0]   wide_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;

  // Batch size the hardware will commit to: request clipped by both limits, floor of one.
  function automatic step_t grant_hint(step_t req, step_t lim, step_t mvl);
    step_t g;
    g = req;
    if (g > lim) g = lim;
    if (g > mvl) g = mvl;
    if (g == '0) g = step_t'(1);
    return g;
  endfunction

  // Sum kept one bit wider so an overshoot past the counter range is still seen.
  function automatic wide_t advance(step_t cur, step_t inc);
    return {1'b0, cur} + {1'b0, inc};
  endfunction

  function automatic logic hits_end(wide_t nxt, step_t vl);
    return nxt >= {1'b0, vl};
  endfunction
endpackage

// File: rtl/vf_hint_grant.sv
module vf_hint_grant
  import vf_step_pkg::*;
#(
  parameter int HW_LIMIT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  step_t req,
  input  step_t mvl,
  output step_t hint
);
  localparam step_t LIM = step_t'(HW_LIMIT);

  step_t granted;
  assign granted = grant_hint(req, LIM, mvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hint <= step_t'(1);
    else if (req_valid) hint <= granted;
  end

  AST_HINT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    hint != '0); // R4
  AST_HINT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    hint <= LIM); // R4
  AST_HINT_MVL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (hint <= $past(mvl) || hint == step_t'(1))); // R4
  AST_HINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(hint)); // R4
endmodule

// File: rtl/vf_step_ctr.sv
module vf_step_ctr
  import vf_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_fire,
  input  step_t hint,
  input  step_t vl,
  input  logic  vf_enter,
  output step_t srcstep,
  output step_t dststep,
  output logic  vf_mode,
  output logic  roll_evt,
  output logic  rollover
);
  wide_t src_next, dst_next;

  assign src_next = advance(srcstep, hint);
  assign dst_next = advance(dststep, hint);
  assign roll_evt = step_fire && (hits_end(src_next, vl) || hits_end(dst_next, vl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcstep  <= '0;
      dststep  <= '0;
      vf_mode  <= 1'b0;
      rollover <= 1'b0;
    end else begin
      rollover <= roll_evt;
      if (step_fire) begin
        if (roll_evt) begin
          srcstep <= '0;
          dststep <= '0;
        end else begin
          srcstep <= src_next[STEP_W-1:0];
          dststep <= dst_next[STEP_W-1:0];
        end
      end
      if (roll_evt) vf_mode <= 1'b0;
      else if (vf_enter) vf_mode <= 1'b1;
    end
  end

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !roll_evt) |=> srcstep == $past(srcstep) + $past(hint)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> ($stable(srcstep) && $stable(dststep) && !rollover)); // R1
  AST_ROLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    roll_evt |=> (srcstep == '0 && dststep == '0 && !vf_mode && rollover)); // R3
  AST_VL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && vl == '0) |=> (rollover && srcstep == '0)); // R8
  AST_ENTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_enter && !roll_evt) |=> vf_mode); // R10
endmodule

// File: rtl/vf_cr_build.sv
module vf_cr_build
  import vf_step_pkg::*;
#(
  parameter int N_LOOP = 4,
  parameter int IMM_W  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IMM_W-1:0]             imm,
  input  logic                         rolled,
  input  logic [N_LOOP*LOOP_FLAGS-1:0] loop_end,
  output cr_t                          cr0,
  output logic                         cr0_valid
);
  localparam int FIRST_STATE_IMM = 2;

  cr_t cand [N_LOOP];
  logic [N_LOOP-1:0] hit;

  for (genvar k = 0; k < N_LOOP; k++) begin : g_state
    assign cand[k] = '{lt: loop_end[k*LOOP_FLAGS+1],
                       gt: loop_end[k*LOOP_FLAGS+2],
                       eq: loop_end[k*LOOP_FLAGS],
                       so: rolled};
    assign hit[k] = (imm == IMM_W'(k + FIRST_STATE_IMM));
  end

  cr_t sel;
  always_comb begin
    sel = '0;
    if (imm == IMM_W'(1)) sel.so = rolled;
    for (int k = 0; k < N_LOOP; k++) begin
      if (hit[k]) sel = cand[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0       <= '0;
      cr0_valid <= 1'b0;
    end else begin
      cr0_valid <= wr_en;
      if (wr_en) cr0 <= sel;
    end
  end

  AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!cr0_valid && $stable(cr0))); // R7
  AST_CR_SO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && imm == IMM_W'(1)) |=> (!cr0.lt && !cr0.gt && !cr0.eq)); // R5
  AST_CR_SO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && imm >= IMM_W'(1) && imm < IMM_W'(N_LOOP + FIRST_STATE_IMM))
      |=> cr0.so == $past(rolled)); // R6
endmodule

// File: rtl/vf_step_seq.sv
module vf_step_seq
  import vf_step_pkg::*;
#(
  parameter int HW_LIMIT = 4,
  parameter int N_LOOP   = 4,
  parameter int IMM_W    = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic                         op_vf,
  input  logic                         op_vs,
  input  logic                         op_ms,
  input  logic                         op_rc,
  input  logic [IMM_W-1:0]             op_imm,
  input  logic [STEP_W-1:0]            vl,
  input  logic [STEP_W-1:0]            mvl,
  input  logic                         hint_valid,
  input  logic [STEP_W-1:0]            hint_req,
  input  logic                         vf_enter,
  input  logic [N_LOOP*LOOP_FLAGS-1:0] loop_end,
  output logic [STEP_W-1:0]            srcstep,
  output logic [STEP_W-1:0]            dststep,
  output logic [STEP_W-1:0]            hint,
  output logic                         vf_mode,
  output logic                         rollover,
  output logic [3:0]                   cr0,
  output logic                         cr0_valid
);
  logic step_fire;
  logic cr_wr;
  logic roll_evt;
  cr_t  cr_q;

  assign step_fire = op_valid && op_vf && !op_vs && !op_ms;
  assign cr_wr     = step_fire && op_rc;

  vf_hint_grant #(.HW_LIMIT(HW_LIMIT)) u_hint (
    .clk(clk), .rst_n(rst_n), .req_valid(hint_valid), .req(hint_req),
    .mvl(mvl), .hint(hint)
  );

  vf_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .step_fire(step_fire), .hint(hint), .vl(vl),
    .vf_enter(vf_enter), .srcstep(srcstep), .dststep(dststep),
    .vf_mode(vf_mode), .roll_evt(roll_evt), .rollover(rollover)
  );

  vf_cr_build #(.N_LOOP(N_LOOP), .IMM_W(IMM_W)) u_cr (
    .clk(clk), .rst_n(rst_n), .wr_en(cr_wr), .imm(op_imm), .rolled(roll_evt),
    .loop_end(loop_end), .cr0(cr_q), .cr0_valid(cr0_valid)
  );

  assign cr0 = cr_q;

  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    srcstep == dststep); // R2
  AST_NONSTEP_NO_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !(op_vf && !op_vs && !op_ms)) |=> !cr0_valid); // R1
  AST_ROLL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> !rollover || $past(step_fire)); // R3
endmodule

// File: tb/vf_step_seq_bench.sv
module vf_step_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW_LIMIT = 4;
  localparam int N_LOOP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_vf = 0, op_vs = 0, op_ms = 0, op_rc = 0;
  logic [6:0] op_imm = '0, vl = '0, mvl = 7'd64, hint_req = '0;
  logic hint_valid = 0, vf_enter = 0;
  logic [11:0] loop_end = '0;
  logic [6:0] srcstep, dststep, hint;
  logic vf_mode, rollover, cr0_valid;
  logic [3:0] cr0;

  vf_step_seq #(.HW_LIMIT(HW_LIMIT), .N_LOOP(N_LOOP)) u_vf_step_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_vf(op_vf), .op_vs(op_vs),
    .op_ms(op_ms), .op_rc(op_rc), .op_imm(op_imm), .vl(vl), .mvl(mvl),
    .hint_valid(hint_valid), .hint_req(hint_req), .vf_enter(vf_enter),
    .loop_end(loop_end), .srcstep(srcstep), .dststep(dststep), .hint(hint),
    .vf_mode(vf_mode), .rollover(rollover), .cr0(cr0), .cr0_valid(cr0_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R9";

  // Behavioural reference state.
  int m_src = 0, m_dst = 0, m_hint = 1, m_cr = 0;
  bit m_vf = 0, m_roll = 0, m_crv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_hint = 1; m_vf = 0; m_roll = 0; m_crv = 0; m_cr = 0;
    end else begin
      int ns, nd, g, st, imm;
      bit step, r;
      step = op_valid && op_vf && !op_vs && !op_ms;
      r = 0;
      m_crv = 0;
      if (step) begin
        ns = m_src + m_hint;
        nd = m_dst + m_hint;
        r = (ns >= int'(vl)) || (nd >= int'(vl));
        if (r) begin m_src = 0; m_dst = 0; end
        else begin m_src = ns; m_dst = nd; end
        if (op_rc) begin
          m_crv = 1;
          imm = int'(op_imm);
          if (imm == 1) m_cr = r ? 1 : 0;
          else if (imm >= 2 && imm <= 5) begin
            st = (imm - 2) * 3;
            m_cr = (loop_end[st+1] << 3) | (loop_end[st+2] << 2) | (loop_end[st] << 1) | r;
          end else m_cr = 0;
        end
      end
      m_roll = r;
      if (r) m_vf = 0;
      else if (vf_enter) m_vf = 1;
      if (hint_valid) begin
        g = int'(hint_req);
        if (g > HW_LIMIT) g = HW_LIMIT;
        if (g > int'(mvl)) g = int'(mvl);
        if (g < 1) g = 1;
        m_hint = g;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("srcstep R2", int'(srcstep), m_src);
      chk("dststep R2", int'(dststep), m_dst);
      chk("hint R4", int'(hint), m_hint);
      chk("vf_mode R3 R10", int'(vf_mode), int'(m_vf));
      chk("rollover R3", int'(rollover), int'(m_roll));
      chk("cr0_valid R7", int'(cr0_valid), int'(m_crv));
      chk("cr0 R5 R6", int'(cr0), m_cr);
    end
  end

  // One operation cycle followed by an idle cycle.
  task automatic op(bit v, bit f, bit s, bit m, bit rc, int imm, bit enter,
                    bit hv, int hr);
    @(negedge clk); #2;
    op_valid = v; op_vf = f; op_vs = s; op_ms = m; op_rc = rc;
    op_imm = 7'(imm); vf_enter = enter; hint_valid = hv; hint_req = 7'(hr);
    @(negedge clk); #2;
    op_valid = 0; op_vf = 0; op_vs = 0; op_ms = 0; op_rc = 0;
    vf_enter = 0; hint_valid = 0;
  endtask

  task automatic step(bit rc, int imm);
    op(1, 1, 0, 0, rc, imm, 0, 0, 0);
  endtask

  task automatic ask(int hr);
    op(0, 0, 0, 0, 0, 0, 0, 1, hr);
  endtask

  initial begin
    cur_tag = "R9";
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);

    cur_tag = "R4";
    mvl = 7'd64;
    ask(0); ask(3); ask(10);
    mvl = 7'd2; ask(4);
    mvl = 7'd0; ask(5);
    mvl = 7'd64; ask(3);

    cur_tag = "R10";
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);

    cur_tag = "R2";
    vl = 7'd20;
    step(0, 0); step(0, 0); step(0, 0);

    cur_tag = "R1";
    op(1, 1, 1, 0, 1, 1, 0, 0, 0);
    op(1, 1, 0, 1, 1, 1, 0, 0, 0);
    op(1, 0, 0, 0, 1, 1, 0, 0, 0);
    op(0, 1, 0, 0, 1, 1, 0, 0, 0);

    cur_tag = "R3";
    vl = 7'd10;
    step(0, 0);

    cur_tag = "R5";
    op(0, 0, 0, 0, 0, 0, 1, 1, 4);
    vl = 7'd6;
    step(1, 1);
    step(1, 1);

    cur_tag = "R6";
    vl = 7'd100;
    loop_end = 12'b101_010_110_001;
    for (int k = 2; k <= 5; k++) step(1, k);
    loop_end = 12'b011_100_111_010;
    for (int k = 2; k <= 5; k++) step(1, k);
    vl = 7'd40;
    step(1, 3);

    cur_tag = "R7";
    vl = 7'd127;
    step(1, 0); step(1, 6); step(1, 7);
    step(1, 1);
    step(0, 2);

    cur_tag = "R8";
    vl = 7'd0;
    step(1, 1); step(0, 0);

    cur_tag = "R10";
    vl = 7'd1;
    op(1, 1, 0, 0, 0, 0, 1, 0, 0);
    op(0, 0, 0, 0, 0, 0, 1, 0, 0);

    cur_tag = "R2";
    vl = 7'd120; ask(1);
    for (int i = 0; i < 5; i++) step(0, 0);

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule